// File: doc/BRIEF.md
# GPIO Output Bank with Set/Clear Registers

This block drives a bank of general-purpose output pins, up to 96 of them, grouped into 32-bit words. Every pin owns one output latch bit and one direction bit. Software never writes a latch word directly. It writes ones into a set word to raise pins, or ones into a clear word to lower them. Zero bits in either word leave their pins untouched. Because of this, two agents can each change their own pins without a read-modify-write race.

The direction word decides whether a pin is driven. The latch keeps its value whatever the direction is. A set or clear aimed at an input pin is stored in the latch. The pad does not see it until software turns the pin into an output, and the stored level appears on that same edge. The register bus is a single-cycle port: a byte address, a write strobe, write data, and combinational read data. It has no wait states. Direction words read back their contents. Set and clear words read as zero.

Top module: `gpo_bank`

## Requirements
- R1: After a synchronous active-low reset, every latch bit and every direction bit is 0. All `pin_out` and `pin_oe` bits are 0, and every direction word reads 0.
- R2: A write to set word k (byte address 0x18 + 4k) raises the latch of pin 32k+b for each bit b written as 1. Bits written as 0 leave their pins unchanged.
- R3: A write to clear word k (byte address 0x24 + 4k) lowers the latch of pin 32k+b for each bit b written as 1. Bits written as 0 leave their pins unchanged.
- R4: Direction word k (byte address 0x0C + 4k) holds one bit per pin, where 1 means output. It reads back what was written, and `pin_oe[32k+b]` equals that bit. In the same cycle as a write, a read of the word returns its old value.
- R5: A set or clear written while a pin is an input keeps `pin_oe` low. It is held in the latch, and it drives `pin_out` as soon as the direction bit of that pin is written to 1.
- R6: A read of any set or clear word returns 0. Writing these words does not alter any direction word.
- R7: Bits of the last word that lie at or above NUM_PINS are reserved. Writes to them have no effect, and they read as 0.
- R8: Writes to an address outside the three register groups have no effect, and reads of such an address return 0. Misaligned addresses (low two bits not 00) also count as outside.
- R9: While `bus_we` is low, no latch or direction bit changes, whatever the address and data are.
- R10: A write changes the outputs on the rising clock edge that samples it. Before that edge the outputs still show the old state.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_out | output | NUM_PINS | Latched output level per pin |
| pin_oe | output | NUM_PINS | Output enable per pin, equal to its direction bit |

## Verification
Two things can share a cycle here. One is a direction write that releases a latch level stored while the pin was an input. The other is a read of a direction word in the same cycle that writes it. The bench stores sets and clears on input pins and then flips the direction. It checks that `pin_oe` and the held level appear together on the edge after the write. It also reads a direction word while a write to it is pending. It expects the old value before the edge and the new value after it.

// File: rtl/gpo_pkg.sv
// Package: shared constants and types for the GPIO output bank.
// Assumes a byte-addressed bus with 32-bit aligned registers.
package gpo_pkg;

    localparam int WORD_W = 32;

    // Word-address bases (byte address >> 2) of the three register groups.
    localparam int DIR_WBASE = 3;   // byte 0x0C
    localparam int SET_WBASE = 6;   // byte 0x18
    localparam int CLR_WBASE = 9;   // byte 0x24

    // Register group selected by an access.
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_DIR  = 2'd1,
        KIND_SET  = 2'd2,
        KIND_CLR  = 2'd3
    } reg_kind_e;

    // Number of live pins in word k of a bank with num_pins pins.
    function automatic int live_bits(int num_pins, int k);
        int rem;
        rem = num_pins - WORD_W * k;
        if (rem > WORD_W) return WORD_W;
        if (rem < 0) return 0;
        return rem;
    endfunction

endpackage

// File: rtl/gpo_addr_decode.sv
// Module: gpo_addr_decode
// Decodes a byte address into a register group and a word index. It
// produces one write strobe per word of each group.
// Assumes: the three groups do not overlap (NUM_WORDS <= 3).
module gpo_addr_decode
    import gpo_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 3,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int WA_W     = ADDR_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output reg_kind_e            kind,
    output logic [IDX_W-1:0]     idx,
    output logic [NUM_WORDS-1:0] dir_we,
    output logic [NUM_WORDS-1:0] set_we,
    output logic [NUM_WORDS-1:0] clr_we
);

    logic [WA_W-1:0] wa;
    logic            aligned;
    logic [WA_W-1:0] off_dir;
    logic [WA_W-1:0] off_set;
    logic [WA_W-1:0] off_clr;

    // Split the byte address into a word address and an alignment flag.
    assign wa      = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    // Offsets of the word address from each group base.
    assign off_dir = wa - WA_W'(DIR_WBASE);
    assign off_set = wa - WA_W'(SET_WBASE);
    assign off_clr = wa - WA_W'(CLR_WBASE);

    // Pick the group that contains the word address, if any.
    always_comb begin
        kind = KIND_NONE;
        idx  = '0;
        if (aligned) begin
            if (wa >= WA_W'(DIR_WBASE) && off_dir < WA_W'(NUM_WORDS)) begin
                kind = KIND_DIR;
                idx  = off_dir[IDX_W-1:0];
            end else if (wa >= WA_W'(SET_WBASE) && off_set < WA_W'(NUM_WORDS)) begin
                kind = KIND_SET;
                idx  = off_set[IDX_W-1:0];
            end else if (wa >= WA_W'(CLR_WBASE) && off_clr < WA_W'(NUM_WORDS)) begin
                kind = KIND_CLR;
                idx  = off_clr[IDX_W-1:0];
            end
        end
    end

    // One write strobe per word and group.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_strobe
        logic hit_k;
        assign hit_k     = we && (idx == IDX_W'(k));
        assign dir_we[k] = hit_k && (kind == KIND_DIR);
        assign set_we[k] = hit_k && (kind == KIND_SET);
        assign clr_we[k] = hit_k && (kind == KIND_CLR);
    end

    // At most one word strobe per access (R8: an undecoded address strobes nothing).
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dir_we, set_we, clr_we}));

    // An undecoded address must never produce a strobe (R8).
    p_undecoded_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_NONE) |-> ({dir_we, set_we, clr_we} == '0));

endmodule

// File: rtl/gpo_dir_bank.sv
// Module: gpo_dir_bank
// Holds the direction bit of every pin, stored word by word. A whole-word
// write replaces the live bits of that word. Reserved bits are not stored.
// Assumes: at most one word strobe per cycle.
module gpo_dir_bank
    import gpo_pkg::*;
#(
    parameter int NUM_PINS  = 80,
    parameter int NUM_WORDS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WORDS-1:0] we,
    input  logic [WORD_W-1:0]    wdata,
    output logic [NUM_PINS-1:0]  dir_q
);

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam int LO = WORD_W * k;
        localparam int W  = live_bits(NUM_PINS, k);

        // Load the live bits of this word on a strobe, or clear them in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_q[LO +: W] <= '0;
            end else if (we[k]) begin
                dir_q[LO +: W] <= wdata[W-1:0];
            end
        end

        // A strobe loads the written data into this word (R4).
        p_dir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            we[k] |=> (dir_q[LO +: W] == $past(wdata[W-1:0])));

        // With no strobe the word keeps its value (R9).
        p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !we[k] |=> $stable(dir_q[LO +: W]));
    end

endmodule

// File: rtl/gpo_out_latch.sv
// Module: gpo_out_latch
// Output latch of every pin, updated by write-one-to-set and write-one-to-
// clear words. The latch does not look at direction, so a level written to
// an input pin is kept until that pin is enabled.
// Assumes: when set and clear hit the same bit in one cycle, set has priority.
module gpo_out_latch
    import gpo_pkg::*;
#(
    parameter int NUM_PINS  = 80,
    parameter int NUM_WORDS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WORDS-1:0] set_we,
    input  logic [NUM_WORDS-1:0] clr_we,
    input  logic [WORD_W-1:0]    wdata,
    output logic [NUM_PINS-1:0]  lat_q
);

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam int LO = WORD_W * k;
        localparam int W  = live_bits(NUM_PINS, k);

        logic [W-1:0] set_v;
        logic [W-1:0] clr_v;
        logic [W-1:0] nxt;

        // Form the per-bit set and clear vectors of this word.
        assign set_v = set_we[k] ? wdata[W-1:0] : '0;
        assign clr_v = clr_we[k] ? wdata[W-1:0] : '0;

        // Next latch value: clear first, then set, so set wins a tie.
        always_comb begin
            nxt = (lat_q[LO +: W] & ~clr_v) | set_v;
        end

        // Register the latch word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q[LO +: W] <= '0;
            end else begin
                lat_q[LO +: W] <= nxt;
            end
        end

        // Every bit written 1 to the set word is high afterwards (R2).
        p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_we[k] |=> ((lat_q[LO +: W] & $past(wdata[W-1:0])) == $past(wdata[W-1:0])));

        // Bits written 0 to the set word keep their value (R2).
        p_set_zero_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (set_we[k] && !clr_we[k]) |=>
                ((lat_q[LO +: W] & ~$past(wdata[W-1:0])) ==
                 ($past(lat_q[LO +: W]) & ~$past(wdata[W-1:0]))));

        // Every bit written 1 to the clear word is low afterwards (R3).
        p_clr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we[k] && !set_we[k]) |=> ((lat_q[LO +: W] & $past(wdata[W-1:0])) == '0));

        // With neither strobe the latch word is stable (R9).
        p_lat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_we[k] && !clr_we[k]) |=> $stable(lat_q[LO +: W]));
    end

endmodule

// File: rtl/gpo_bank.sv
// Module: gpo_bank (top)
// GPIO output bank: register decode, direction words, output latches and
// the read multiplexer. Pin outputs come straight from the latch and the
// direction registers.
// Assumes: 1 <= NUM_PINS <= 96, and single-cycle bus writes with no wait states.
module gpo_bank
    import gpo_pkg::*;
#(
    parameter int NUM_PINS = 80,
    parameter int ADDR_W   = 8,
    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int TOT_W     = NUM_WORDS * WORD_W,
    localparam int LAST_W    = NUM_PINS - WORD_W * (NUM_WORDS - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    reg_kind_e            acc_kind;
    logic [IDX_W-1:0]     acc_idx;
    logic [NUM_WORDS-1:0] dir_we;
    logic [NUM_WORDS-1:0] set_we;
    logic [NUM_WORDS-1:0] clr_we;
    logic [NUM_PINS-1:0]  dir_q;
    logic [NUM_PINS-1:0]  lat_q;
    logic [TOT_W-1:0]     dir_pad;

    // Address decode and per-word write strobes.
    gpo_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .kind   (acc_kind),
        .idx    (acc_idx),
        .dir_we (dir_we),
        .set_we (set_we),
        .clr_we (clr_we)
    );

    // Direction storage.
    gpo_dir_bank #(
        .NUM_PINS  (NUM_PINS),
        .NUM_WORDS (NUM_WORDS)
    ) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dir_we),
        .wdata (bus_wdata),
        .dir_q (dir_q)
    );

    // Output latches with set and clear.
    gpo_out_latch #(
        .NUM_PINS  (NUM_PINS),
        .NUM_WORDS (NUM_WORDS)
    ) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we),
        .clr_we (clr_we),
        .wdata  (bus_wdata),
        .lat_q  (lat_q)
    );

    // Zero-extend the direction bits to whole words for the read path.
    assign dir_pad = TOT_W'(dir_q);

    // Read multiplexer: only direction words return data.
    always_comb begin
        bus_rdata = '0;
        if (acc_kind == KIND_DIR) begin
            bus_rdata = dir_pad[acc_idx * WORD_W +: WORD_W];
        end
    end

    // Pins follow the latch. Enables follow the direction bits.
    assign pin_out = lat_q;
    assign pin_oe  = dir_q;

    // Set and clear words are write-only and read back as zero (R6).
    p_wo_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == KIND_SET || acc_kind == KIND_CLR) |-> (bus_rdata == '0));

    // A set or clear access never touches the enables (R6).
    p_wo_keeps_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == KIND_SET || acc_kind == KIND_CLR) |=> $stable(pin_oe));

    // Reserved bits of the last direction word read as zero (R7).
    if (LAST_W < WORD_W) begin : g_resv
        p_resv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_kind == KIND_DIR && acc_idx == IDX_W'(NUM_WORDS - 1)) |->
                (bus_rdata[WORD_W-1:LAST_W] == '0));
    end

endmodule

// File: tb/gpo_bank_tb_top.sv
// Directed testbench for gpo_bank. Each scenario is a task that checks its
// own results against bench-side expected pin and enable vectors.
module gpo_bank_tb_top;

    localparam int NP = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [NP-1:0] exp_lat = '0;
    logic [NP-1:0] exp_dir = '0;

    always #5 clk = ~clk;

    gpo_bank #(.NUM_PINS(NP), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_pins(string req);
        chk({req, " pin_out"}, 96'(pin_out), 96'(exp_lat));
        chk({req, " pin_oe"}, 96'(pin_oe), 96'(exp_dir));
    endtask

    // One bus write. It returns at the negedge after the sampling edge.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Bench model of the live bits of word k.
    function automatic logic [NP-1:0] wmask(int k, logic [31:0] d);
        logic [NP-1:0] m;
        m = '0;
        for (int b = 0; b < 32; b++)
            if (32 * k + b < NP && d[b]) m[32 * k + b] = 1'b1;
        return m;
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        chk_pins("R1");
        for (int k = 0; k < 3; k++) begin
            rd(8'h0C + 8'(4 * k), d);
            chk("R1 dir read", 96'(d), 96'h0);
        end
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_addr = 8'h18; bus_wdata = 32'h1; bus_we = 1'b1;
        #1;
        chk("R10 before edge", 96'(pin_out[0]), 96'h0);
        @(posedge clk);
        #1;
        chk("R10 after edge", 96'(pin_out[0]), 96'h1);
        @(negedge clk);
        bus_we = 1'b0;
        exp_lat[0] = 1'b1;
        chk_pins("R10");
    endtask

    task automatic t_set;
        wr(8'h1C, 32'hA5A5_0F0F);
        exp_lat |= wmask(1, 32'hA5A5_0F0F);
        chk_pins("R2 word1");
        wr(8'h20, 32'h0000_8001);
        exp_lat |= wmask(2, 32'h0000_8001);
        chk_pins("R2 word2");
        wr(8'h18, 32'h0);
        chk_pins("R2 zero write");
    endtask

    task automatic t_clear;
        wr(8'h28, 32'h0000_0F00);
        exp_lat &= ~wmask(1, 32'h0000_0F00);
        chk_pins("R3 word1");
        wr(8'h24, 32'h0000_0001);
        exp_lat &= ~wmask(0, 32'h1);
        chk_pins("R3 word0");
        wr(8'h2C, 32'h0);
        chk_pins("R3 zero write");
    endtask

    task automatic t_dir;
        logic [31:0] d;
        wr(8'h10, 32'hFFFF_0000);
        exp_dir |= wmask(1, 32'hFFFF_0000);
        chk_pins("R4 enable");
        rd(8'h10, d);
        chk("R4 readback", 96'(d), 96'hFFFF_0000);
        // Read in the same cycle as a write returns the old word.
        @(negedge clk);
        bus_addr = 8'h10; bus_wdata = 32'h0000_00F0; bus_we = 1'b1;
        #1;
        chk("R4 same-cycle old", 96'(bus_rdata), 96'hFFFF_0000);
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        chk("R4 new value", 96'(bus_rdata), 96'h0000_00F0);
        exp_dir &= ~wmask(1, 32'hFFFF_FFFF);
        exp_dir |= wmask(1, 32'h0000_00F0);
        chk_pins("R4 rewrite");
    endtask

    task automatic t_hold;
        wr(8'h18, 32'h0000_0020);
        exp_lat[5] = 1'b1;
        chk_pins("R5 set on input");
        wr(8'h24, 32'h0000_0040);
        exp_lat[6] = 1'b0;
        wr(8'h0C, 32'h0000_0060);
        exp_dir[6:5] = 2'b11;
        chk_pins("R5 released");
        chk("R5 pin5 level", 96'(pin_out[5]), 96'h1);
    endtask

    task automatic t_wo;
        logic [31:0] d;
        rd(8'h18, d); chk("R6 set read", 96'(d), 96'h0);
        rd(8'h2C, d); chk("R6 clr read", 96'(d), 96'h0);
        wr(8'h1C, 32'hFFFF_FFFF);
        exp_lat |= wmask(1, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R6 dir untouched", 96'(d), 96'h0000_0060);
        chk_pins("R6");
    endtask

    task automatic t_resv;
        logic [31:0] d;
        wr(8'h14, 32'hFFFF_FFFF);
        exp_dir |= wmask(2, 32'hFFFF_FFFF);
        rd(8'h14, d);
        chk("R7 reserved read", 96'(d), 96'h0000_FFFF);
        wr(8'h20, 32'hFFFF_0000);
        chk_pins("R7 reserved set");
    endtask

    task automatic t_undec;
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h19, 32'hFFFF_FFFF);
        wr(8'h25, 32'hFFFF_FFFF);
        chk_pins("R8");
        rd(8'h30, d); chk("R8 read 0x30", 96'(d), 96'h0);
        rd(8'h0D, d); chk("R8 read misaligned", 96'(d), 96'h0);
    endtask

    task automatic t_we_low;
        @(negedge clk);
        bus_addr = 8'h24; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
        @(negedge clk);
        bus_addr = 8'h0C;
        @(negedge clk);
        chk_pins("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_set();
        t_clear();
        t_dir();
        t_hold();
        t_wo();
        t_resv();
        t_undec();
        t_we_low();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule